// File: doc/BRIEF.md
# Swept Line Sensor Readout Sequencer

This block drives the readout of a swept-line image sensor whose array holds 8 rows and 280 image columns, plus one dummy column used for calibration and for marking the start of a frame. On every pixel clock it selects one column and one pair of rows, an even row and an odd row. The two external converters return a 4-bit result for each row of the pair. The block latches both results and presents them together as one byte on the next clock.

Columns are visited in index order and wrap to the first after the last. Index 0 is the dummy column, so every frame begins with it. Each column yields four bytes, for row pairs 0/1, 2/3, 4/5 and 6/7 in that order, so one frame is 281 x 4 = 1124 bytes. Frames repeat for as long as the block is active. Frame and column markers travel with the bytes, and a frame counter numbers the frames.

A nap input puts the block into a low-power state. While nap is asserted the sequencer is held at its home position, the internal clock enable and the temperature stabilization enable are dropped, and the output driver enable is released so that the data pins can float. Leaving nap restarts the readout at the dummy column and row pair 0.

Top module: `readout_seq`

## Requirements
- R1: While reset is applied, and on the first clock after it is released, the selection is column 0, row pair 0, and byte_valid_o, data_oe_o, clk_run_o, temp_stab_en_o and pix_byte_o are all 0.
- R2: When not in nap, pair_sel_o steps 0, 1, 2, 3 on successive clocks, and col_sel_o holds its value until pair 3 has been selected.
- R3: col_sel_o stays in the range 0 to 280 and advances by one after pair 3. After column 280 pair 3 it wraps to column 0, which is the dummy column.
- R4: The byte for a selection appears on pix_byte_o one clock after that selection. Bits [3:0] carry the even-row sample and bits [7:4] carry the odd-row sample that were present during the selecting clock.
- R5: byte_valid_o is 1 in exactly those cycles whose previous cycle was an active (non-nap, out of reset) cycle.
- R6: frame_start_o is 1 only together with the byte of column 0, pair 0.
- R7: col_start_o is 1 together with every pair-0 byte, and only then.
- R8: frame_cnt_o increments by one, wrapping, on the same clock that raises frame_start_o, and is cleared by reset and by nap.
- R9: One clock after nap_i is sampled high, data_oe_o, clk_run_o, temp_stab_en_o and byte_valid_o are 0 and pix_byte_o is 0, whatever the converter inputs are. These signals are 1 again one clock after an active cycle.
- R10: A clock that samples nap_i high puts the selection at column 0, pair 0, so the first active cycle after nap reads column 0, pair 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nap_i | input | 1 | Low-power nap request |
| even_smp_i | input | 4 | Converter result for the selected even row |
| odd_smp_i | input | 4 | Converter result for the selected odd row |
| col_sel_o | output | 9 | Selected column, 0 is the dummy column |
| pair_sel_o | output | 2 | Selected row pair (rows 2k and 2k+1) |
| pix_byte_o | output | 8 | Packed byte: odd row in [7:4], even row in [3:0] |
| byte_valid_o | output | 1 | Strobe that comes with every output byte |
| frame_start_o | output | 1 | Marks the first byte of a frame |
| col_start_o | output | 1 | Marks the first byte of each column |
| frame_cnt_o | output | 16 | Number of frames started since reset or nap |
| data_oe_o | output | 1 | Enable for the data pin drivers, 0 lets them float |
| clk_run_o | output | 1 | Internal clock enable |
| temp_stab_en_o | output | 1 | Temperature stabilization enable |

## Verification
The assertions check on every clock that pairs step in order, that the column holds within a column and wraps after 280, that a nap sends the selection home and silences the outputs, that frame_start never appears without col_start, and that the packed byte equals the nibbles of the previous clock. The bench's scenarios cover what spans many clocks: whole frames of 1124 bytes wrapping cleanly, frame counts that agree over several frames, naps entered part-way through a frame followed by a restart at the dummy column, and converter inputs toggling during nap without reaching the pins.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  localparam int unsigned DEF_ROWS       = 8;
  localparam int unsigned DEF_IMG_COLS   = 280;
  localparam int unsigned DEF_DUMMY_COLS = 1;
  localparam int unsigned DEF_SMP_W      = 4;
  localparam int unsigned DEF_FRAME_W    = 16;

  // markers that travel beside a selection into the output stage
  typedef struct packed {
    logic frame_head;
    logic col_head;
  } mark_t;

  // wrapping increment of an index whose top value is last
  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned last);
    return (v >= last) ? 0 : v + 1;
  endfunction

  // odd sample above even sample, w bits each
  function automatic logic [15:0] pack_pair(input logic [7:0] ev, input logic [7:0] od,
                                            input int unsigned w);
    return (16'(od) << w) | 16'(ev);
  endfunction
endpackage

// File: rtl/ssr_seq.sv
module ssr_seq #(
  parameter int unsigned COLS   = 281,
  parameter int unsigned PAIRS  = 4,
  parameter int unsigned COL_W  = 9,
  parameter int unsigned PAIR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nap_i,
  output logic [COL_W-1:0]  col_o,
  output logic [PAIR_W-1:0] pair_o,
  output ssr_pkg::mark_t    mark_o
);
  import ssr_pkg::*;

  logic [COL_W-1:0]  col_q;
  logic [PAIR_W-1:0] pair_q;
  logic              last_pair;
  logic              last_col;

  assign last_pair = (pair_q == PAIR_W'(PAIRS - 1));
  assign last_col  = (col_q == COL_W'(COLS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || nap_i) begin
      col_q  <= '0;
      pair_q <= '0;
    end else begin
      pair_q <= PAIR_W'(wrap_inc(32'(pair_q), PAIRS - 1));
      if (last_pair)
        col_q <= COL_W'(wrap_inc(32'(col_q), COLS - 1));
    end
  end

  assign col_o             = col_q;
  assign pair_o            = pair_q;
  assign mark_o.col_head   = (pair_q == '0);
  assign mark_o.frame_head = (pair_q == '0) && (col_q == '0);

  // R2
  pair_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nap_i && !last_pair) |=> (pair_q == $past(pair_q) + 1'b1));
  // R2
  col_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nap_i && !last_pair) |=> $stable(col_q));
  // R3
  col_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nap_i && last_pair && last_col) |=> (col_q == '0 && pair_q == '0));
  // R3
  col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_q <= COL_W'(COLS - 1));
  // R10
  nap_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nap_i |=> (col_q == '0 && pair_q == '0));
endmodule

// File: rtl/ssr_packer.sv
module ssr_packer #(
  parameter int unsigned SMP_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_i,
  input  logic [SMP_W-1:0]   even_i,
  input  logic [SMP_W-1:0]   odd_i,
  input  ssr_pkg::mark_t     mark_i,
  output logic [2*SMP_W-1:0] byte_o,
  output logic               valid_o,
  output logic               frame_start_o,
  output logic               col_start_o
);
  import ssr_pkg::*;

  logic [15:0] packed_w;
  assign packed_w = pack_pair(8'(even_i), 8'(odd_i), SMP_W);

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i) begin
      byte_o        <= '0;
      valid_o       <= 1'b0;
      frame_start_o <= 1'b0;
      col_start_o   <= 1'b0;
    end else begin
      byte_o        <= packed_w[2*SMP_W-1:0];
      valid_o       <= 1'b1;
      frame_start_o <= mark_i.frame_head;
      col_start_o   <= mark_i.col_head;
    end
  end

  // R4
  pack_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |=> (byte_o[SMP_W-1:0] == $past(even_i) && byte_o[2*SMP_W-1:SMP_W] == $past(odd_i)));
  // R6
  fs_with_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |-> (col_start_o && valid_o));
  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (byte_o == '0 && !col_start_o));
endmodule

// File: rtl/ssr_power.sv
module ssr_power (
  input  logic clk,
  input  logic rst_n,
  input  logic nap_i,
  output logic run_o,
  output logic clk_run_o,
  output logic temp_stab_en_o,
  output logic data_oe_o
);
  logic awake_q;

  always_ff @(posedge clk) begin
    if (!rst_n) awake_q <= 1'b0;
    else        awake_q <= !nap_i;
  end

  assign run_o          = rst_n && !nap_i;
  assign clk_run_o      = awake_q;
  assign temp_stab_en_o = awake_q;
  assign data_oe_o      = awake_q;

  // R9
  nap_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nap_i |=> (!data_oe_o && !clk_run_o && !temp_stab_en_o));
  // R9
  wake_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nap_i |=> data_oe_o);
endmodule

// File: rtl/ssr_frame_cnt.sv
module ssr_frame_cnt #(
  parameter int unsigned FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               nap_i,
  input  logic               frame_head_i,
  output logic [FRAME_W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (!rst_n || nap_i)  cnt_o <= '0;
    else if (frame_head_i) cnt_o <= cnt_o + 1'b1;
  end

  // R8
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nap_i |=> (cnt_o == '0));
  // R8
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nap_i && frame_head_i) |=> (cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: rtl/readout_seq.sv
module readout_seq #(
  parameter int unsigned ROWS       = ssr_pkg::DEF_ROWS,
  parameter int unsigned IMG_COLS   = ssr_pkg::DEF_IMG_COLS,
  parameter int unsigned DUMMY_COLS = ssr_pkg::DEF_DUMMY_COLS,
  parameter int unsigned SMP_W      = ssr_pkg::DEF_SMP_W,
  parameter int unsigned FRAME_W    = ssr_pkg::DEF_FRAME_W,
  localparam int unsigned COLS      = IMG_COLS + DUMMY_COLS,
  localparam int unsigned PAIRS     = ROWS / 2,
  localparam int unsigned COL_W     = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int unsigned PAIR_W    = (PAIRS > 1) ? $clog2(PAIRS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               nap_i,
  input  logic [SMP_W-1:0]   even_smp_i,
  input  logic [SMP_W-1:0]   odd_smp_i,
  output logic [COL_W-1:0]   col_sel_o,
  output logic [PAIR_W-1:0]  pair_sel_o,
  output logic [2*SMP_W-1:0] pix_byte_o,
  output logic               byte_valid_o,
  output logic               frame_start_o,
  output logic               col_start_o,
  output logic [FRAME_W-1:0] frame_cnt_o,
  output logic               data_oe_o,
  output logic               clk_run_o,
  output logic               temp_stab_en_o
);
  import ssr_pkg::*;

  mark_t sel_mark;
  logic  run;

  ssr_seq #(.COLS(COLS), .PAIRS(PAIRS), .COL_W(COL_W), .PAIR_W(PAIR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .nap_i(nap_i),
    .col_o(col_sel_o), .pair_o(pair_sel_o), .mark_o(sel_mark)
  );

  ssr_power u_pwr (
    .clk(clk), .rst_n(rst_n), .nap_i(nap_i), .run_o(run),
    .clk_run_o(clk_run_o), .temp_stab_en_o(temp_stab_en_o), .data_oe_o(data_oe_o)
  );

  ssr_packer #(.SMP_W(SMP_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .run_i(run),
    .even_i(even_smp_i), .odd_i(odd_smp_i), .mark_i(sel_mark),
    .byte_o(pix_byte_o), .valid_o(byte_valid_o),
    .frame_start_o(frame_start_o), .col_start_o(col_start_o)
  );

  ssr_frame_cnt #(.FRAME_W(FRAME_W)) u_fcnt (
    .clk(clk), .rst_n(rst_n), .nap_i(nap_i),
    .frame_head_i(sel_mark.frame_head), .cnt_o(frame_cnt_o)
  );

  // R5
  valid_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid_o |-> data_oe_o);
  // R6
  fs_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start_o && data_oe_o) |-> (col_sel_o == '0 && pair_sel_o == PAIR_W'(1 % PAIRS)));
endmodule

// File: tb/readout_seq_tb.sv
module readout_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       nap_i = 1'b0;
  logic [3:0] even_smp_i = '0;
  logic [3:0] odd_smp_i = '0;
  logic [8:0] col_sel_o;
  logic [1:0] pair_sel_o;
  logic [7:0] pix_byte_o;
  logic       byte_valid_o, frame_start_o, col_start_o;
  logic [15:0] frame_cnt_o;
  logic       data_oe_o, clk_run_o, temp_stab_en_o;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // model state
  int  m_col = 0, m_pair = 0, m_fcnt = 0;
  bit  d_run = 0;
  int  d_col = 0, d_pair = 0;
  logic [3:0] d_ev = '0, d_od = '0;

  always #10 clk = ~clk;

  readout_seq u_dut (
    .clk(clk), .rst_n(rst_n), .nap_i(nap_i),
    .even_smp_i(even_smp_i), .odd_smp_i(odd_smp_i),
    .col_sel_o(col_sel_o), .pair_sel_o(pair_sel_o), .pix_byte_o(pix_byte_o),
    .byte_valid_o(byte_valid_o), .frame_start_o(frame_start_o), .col_start_o(col_start_o),
    .frame_cnt_o(frame_cnt_o), .data_oe_o(data_oe_o), .clk_run_o(clk_run_o),
    .temp_stab_en_o(temp_stab_en_o)
  );

  function automatic int exp_byte(input logic [3:0] ev, input logic [3:0] od);
    return int'(od) * 16 + int'(ev);
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // one pixel clock: check selection, drive, clock, then check outputs
  task automatic cycle(input bit nap_v, input bit quiet_pattern);
    chk(col_sel_o == 9'(m_col), "R3 column select", int'(col_sel_o), m_col);
    chk(pair_sel_o == 2'(m_pair), "R2 pair select", int'(pair_sel_o), m_pair);
    nap_i = nap_v;
    if (quiet_pattern) begin
      even_smp_i = 4'hA; odd_smp_i = 4'h5;
    end else begin
      even_smp_i = 4'($urandom());
      odd_smp_i  = 4'($urandom());
    end
    d_run = !nap_v; d_col = m_col; d_pair = m_pair; d_ev = even_smp_i; d_od = odd_smp_i;
    @(posedge clk);
    @(negedge clk);
    if (d_run) begin
      if (d_col == 0 && d_pair == 0) m_fcnt = (m_fcnt + 1) % 65536;
      m_pair = (d_pair + 1) % 4;
      m_col  = (d_pair == 3) ? (d_col + 1) % 281 : d_col;
    end else begin
      m_col = 0; m_pair = 0; m_fcnt = 0;
    end
    chk(byte_valid_o == d_run, "R5 byte valid", int'(byte_valid_o), int'(d_run));
    chk(data_oe_o == d_run && clk_run_o == d_run && temp_stab_en_o == d_run,
        "R9 power enables", int'({data_oe_o, clk_run_o, temp_stab_en_o}), d_run ? 7 : 0);
    chk(int'(pix_byte_o) == (d_run ? exp_byte(d_ev, d_od) : 0), "R4 packed byte",
        int'(pix_byte_o), d_run ? exp_byte(d_ev, d_od) : 0);
    chk(frame_start_o == (d_run && d_col == 0 && d_pair == 0), "R6 frame start",
        int'(frame_start_o), int'(d_run && d_col == 0 && d_pair == 0));
    chk(col_start_o == (d_run && d_pair == 0), "R7 column start",
        int'(col_start_o), int'(d_run && d_pair == 0));
    chk(int'(frame_cnt_o) == m_fcnt, "R8 frame count", int'(frame_cnt_o), m_fcnt);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(col_sel_o == 0 && pair_sel_o == 0, "R1 reset selection", int'(col_sel_o), 0);
    chk(!byte_valid_o && !data_oe_o && !clk_run_o && !temp_stab_en_o && pix_byte_o == 0,
        "R1 reset outputs", int'({byte_valid_o, data_oe_o, clk_run_o, temp_stab_en_o}), 0);
    rst_n = 1'b1;
    // R1 first cycle after release
    chk(!data_oe_o && !byte_valid_o, "R1 first cycle idle", int'(data_oe_o), 0);
    // directed nibble placement and frame wrap: just over three frames
    for (int i = 0; i < 8; i++) cycle(1'b0, 1'b1);
    for (int i = 0; i < 3400; i++) cycle(1'b0, 1'b0);
    chk(int'(frame_cnt_o) == 4, "R8 three wraps seen", int'(frame_cnt_o), 4);
    // R9 R10 nap mid-frame with inputs still toggling
    for (int i = 0; i < 20; i++) cycle(1'b1, 1'b0);
    chk(data_oe_o == 0 && pix_byte_o == 0, "R9 nap floats data", int'(pix_byte_o), 0);
    chk(col_sel_o == 0 && pair_sel_o == 0, "R10 nap home", int'(col_sel_o), 0);
    for (int i = 0; i < 1200; i++) cycle(1'b0, 1'b0);
    // random nap episodes
    for (int k = 0; k < 6; k++) begin
      int run_len = 50 + int'($urandom() % 700);
      int nap_len = 1 + int'($urandom() % 6);
      for (int i = 0; i < nap_len; i++) cycle(1'b1, 1'b0);
      for (int i = 0; i < run_len; i++) cycle(1'b0, 1'b0);
    end
    // single-cycle nap right at a column boundary
    while (!(m_pair == 3)) cycle(1'b0, 1'b0);
    cycle(1'b1, 1'b0);
    chk(col_sel_o == 0 && pair_sel_o == 0, "R10 restart at dummy column", int'(col_sel_o), 0);
    for (int i = 0; i < 10; i++) cycle(1'b0, 1'b0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    #(20 * 30000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule